// File: doc/BRIEF.md
# Encoded-Timeout Watchdog Timer

This block guards a system against a stalled processor. Software programs a single 8-bit control value. The two low bits choose a resolution of 1, 4, 16 or 64 ticks. The next five bits give a multiplier. The product of the two is the timeout, counted in periods of an external 1/16-second tick strobe. Writing the control value stores it and starts a fresh countdown. Reading it through the read strobe starts the countdown again from the same value. Either restart clears a sticky expiry flag.

If the countdown runs out before software restarts it, the flag is set. The top bit of the control value then picks the action. When that bit is set, the block raises a one-cycle reset request. It also raises a one-cycle clear strobe for a bit held in a neighbouring register, and it wipes the control value to zero, so the watchdog stays off until it is written again. When the top bit is clear, the block gives a single one-cycle interrupt pulse, and the countdown stays idle until the next restart.

The block does not derive the tick from the system clock; the tick arrives as an input strobe.

Top module: `wdg_encoded_timer`

## Requirements
- R1: With resolution field res = bits [1:0] and multiplier mul = bits [6:2], the timeout T equals mul × 4^res ticks. The expiry takes effect at the clock edge that samples the T-th tick after a restart, and its outputs are visible right after that edge.
- R2: A write strobe stores wr_data_i, which shows on ctrl_o after the next edge. The write restarts the countdown from the new value and clears the flag.
- R3: A read strobe without a write restarts the countdown from the value currently stored. It clears the flag and leaves ctrl_o unchanged.
- R4: A restart with T = 0 disables the watchdog, so no expiry follows. This covers a control value of zero and any value whose multiplier field is zero.
- R5: An expiry sets wd_flag_o. The flag stays set until the next write or read strobe.
- R6: An expiry with bit 7 set drives rst_req_o and aux_clr_o high for exactly one cycle. It also clears ctrl_o to 0x00, and no further expiry happens until a new write.
- R7: An expiry with bit 7 clear drives irq_o high for exactly one cycle. rst_req_o stays low and ctrl_o is kept. The watchdog then stays idle until the next restart.
- R8: A write or read strobe in the same cycle as the final tick wins. No expiry occurs, and the countdown reloads.
- R9: When a write and a read strobe coincide, the write governs both the stored value and the reload.
- R10: After reset, ctrl_o is 0x00, all pulse outputs and the flag are low, and the watchdog is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe every 1/16 second |
| wr_en_i | input | 1 | Write strobe for the control value |
| wr_data_i | input | 8 | Control value to store |
| rd_en_i | input | 1 | Read strobe; restarts the countdown |
| ctrl_o | output | 8 | Stored control value |
| wd_flag_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| aux_clr_o | output | 1 | One-cycle clear strobe for the neighbouring register bit |

## Verification
The countdown's last tick can land in the same cycle as a restart, and a write can land in the same cycle as a read. Directed sequences load a one-tick timeout and then present the tick together with a read strobe, and separately together with a write. They also present a tick together with a write and a read at once. The behavioural model applies the restart first and skips the expiry in that cycle. Every cycle, the outputs must show no pulse, a clear flag and the value chosen by the write. Random phases then drop short timeouts and strobes onto ticks so that these collisions recur under both steering settings.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int RES_W     = 2;
  localparam int MUL_W     = 5;
  localparam int CTRL_W    = 8;
  localparam int STEER_BIT = CTRL_W - 1;
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MUL_W + MAX_SHIFT;

  typedef struct packed {
    logic rst;
    logic irq;
    logic aux;
  } wdg_evt_t;

  // timeout in ticks = multiplier scaled by 4^resolution
  function automatic logic [CNT_W-1:0] wdg_timeout(input logic [CTRL_W-1:0] v);
    logic [CNT_W-1:0] m;
    m = CNT_W'(v[RES_W+MUL_W-1:RES_W]);
    return m << {v[RES_W-1:0], 1'b0};
  endfunction
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              clr_i,
  output logic [CTRL_W-1:0] ctrl_q_o,
  output logic              restart_o,
  output logic [CNT_W-1:0]  load_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= wr_data_i;
    end else if (clr_i) begin
      ctrl_q <= '0;
    end
  end

  assign restart_o = wr_en_i | rd_en_i;
  assign load_o    = wdg_timeout(wr_en_i ? wr_data_i : ctrl_q);
  assign ctrl_q_o  = ctrl_q;

  assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ctrl_q == $past(wr_data_i));
  assert_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i) |=> $stable(ctrl_q));
  assert_steer_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ctrl_q == '0);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             last_tick;

  assign last_tick = tick_i && armed_q && (cnt_q == CNT_W'(1));
  assign expire_o  = last_tick && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= load_i;
      armed_q <= (load_i != '0);
    end else if (tick_i && armed_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) armed_q <= 1'b0;
    end
  end

  assert_zero_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && load_i == '0) |=> !armed_q);
  assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && tick_i) |-> !expire_o);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(cnt_q) && $stable(armed_q));
  assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !armed_q);
endmodule

// File: rtl/wdg_action.sv
module wdg_action
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire_i,
  input  logic     steer_i,
  input  logic     restart_i,
  output logic     flag_o,
  output wdg_evt_t evt_o
);
  logic     flag_q;
  wdg_evt_t evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      if (restart_i)     flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
      evt_q.rst <= expire_i && steer_i;
      evt_q.aux <= expire_i && steer_i;
      evt_q.irq <= expire_i && !steer_i;
    end
  end

  assign flag_o = flag_q;
  assign evt_o  = evt_q;

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !restart_i) |=> flag_q);
  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !flag_q);
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.rst |=> !evt_q.rst);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.irq |=> !evt_q.irq);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt_q.rst, evt_q.irq}) <= 1);
endmodule

// File: rtl/wdg_encoded_timer.sv
module wdg_encoded_timer
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              wd_flag_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              aux_clr_o
);
  logic              restart;
  logic [CNT_W-1:0]  load_val;
  logic              expire;
  logic              steer;
  logic              steer_clr;
  logic [CTRL_W-1:0] ctrl_q;
  wdg_evt_t          evt;

  assign steer     = ctrl_q[STEER_BIT];
  assign steer_clr = expire && steer;

  wdg_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .clr_i     (steer_clr),
    .ctrl_q_o  (ctrl_q),
    .restart_o (restart),
    .load_o    (load_val)
  );

  wdg_countdown u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (restart),
    .load_i    (load_val),
    .expire_o  (expire)
  );

  wdg_action u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .steer_i   (steer),
    .restart_i (restart),
    .flag_o    (wd_flag_o),
    .evt_o     (evt)
  );

  assign ctrl_o    = ctrl_q;
  assign rst_req_o = evt.rst;
  assign irq_o     = evt.irq;
  assign aux_clr_o = evt.aux;

  assert_reset_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> aux_clr_o && ctrl_o == '0);
  assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && tick_i) |=> !irq_o && !rst_req_o);
  assert_write_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && rd_en_i) |=> ctrl_o == $past(wr_data_i));
endmodule

// File: tb/wdg_encoded_timer_tb_top.sv
`timescale 1ns/1ps
module wdg_encoded_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl;
  logic       flag, rst_req, irq, aux;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R10 reset";

  int m_ctrl = 0, m_cnt = 0;
  bit m_armed = 0, m_flag = 0, m_rst = 0, m_irq = 0, m_aux = 0;

  always #2.5 clk = ~clk;

  wdg_encoded_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .ctrl_o(ctrl),
    .wd_flag_o(flag), .rst_req_o(rst_req), .irq_o(irq), .aux_clr_o(aux)
  );

  function automatic int ticks_for(int v);
    int res = v % 4;
    int mul = (v / 4) % 32;
    int k = 1;
    for (int i = 0; i < res; i++) k = k * 4;
    return mul * k;
  endfunction

  task automatic model(bit t, bit w, int d, bit r);
    m_rst = 0; m_irq = 0; m_aux = 0;
    if (w) begin
      m_ctrl = d; m_cnt = ticks_for(d); m_armed = (m_cnt != 0); m_flag = 0;
    end else if (r) begin
      m_cnt = ticks_for(m_ctrl); m_armed = (m_cnt != 0); m_flag = 0;
    end else if (t && m_armed) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        m_armed = 0; m_flag = 1;
        if (m_ctrl >= 128) begin m_ctrl = 0; m_rst = 1; m_aux = 1; end
        else m_irq = 1;
      end
    end
  endtask

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    cmp("ctrl_o (R2)", int'(ctrl), m_ctrl);
    cmp("wd_flag_o (R5)", int'(flag), int'(m_flag));
    cmp("rst_req_o (R6)", int'(rst_req), int'(m_rst));
    cmp("aux_clr_o (R6)", int'(aux), int'(m_aux));
    cmp("irq_o (R7)", int'(irq), int'(m_irq));
  endtask

  task automatic step(bit t, bit w, int d, bit r);
    @(negedge clk);
    tick = t; wr_en = w; wr_data = 8'(d); rd_en = r;
    model(t, w, d, r);
    @(posedge clk); #1;
    cmp_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    cmp_all();                       // R10 outputs after reset
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R10 idle after reset";
    ticks(10);

    cur_req = "R1 res1 mul1 = 4 ticks, irq";
    step(0, 1, 8'h05, 0);
    ticks(3);
    cmp("R1 flag before T", int'(flag), 0);
    ticks(1);
    cmp("R1 flag at T", int'(flag), 1);
    cur_req = "R7 one-shot idle";
    ticks(12);
    cmp("R7 ctrl kept", int'(ctrl), 8'h05);

    cur_req = "R3 read re-arms";
    step(0, 0, 0, 1);
    cmp("R3 flag cleared", int'(flag), 0);
    ticks(2); step(0, 0, 0, 1); ticks(3); ticks(1);

    cur_req = "R6 reset steered";
    step(0, 1, 8'h8A, 0);            // res2 mul2 = 32 ticks
    ticks(40);
    cmp("R6 ctrl zero", int'(ctrl), 0);
    step(0, 0, 0, 1); ticks(10);     // stays disabled after read

    cur_req = "R4 zero multiplier";
    step(0, 1, 8'h83, 0); ticks(100);
    step(0, 1, 8'h00, 0); ticks(30);

    cur_req = "R8 read on final tick";
    step(0, 1, 8'h04, 0);
    step(1, 0, 0, 1);
    cmp("R8 no irq", int'(irq), 0);
    cur_req = "R8 write on final tick";
    step(1, 1, 8'h84, 0);
    step(1, 0, 0, 0);
    cmp("R8 reload then expiry", int'(rst_req), 1);

    cur_req = "R9 write beats read";
    step(0, 1, 8'h08, 0);
    step(1, 1, 8'h05, 1);
    ticks(4);
    cmp("R9 irq from write value", int'(flag), 1);

    cur_req = "R1 longest timeout";
    step(0, 1, 8'hFF, 0);
    ticks(1983);
    cmp("R1 no flag yet", int'(flag), 0);
    ticks(1);
    cmp("R1 rst at 1984", int'(rst_req), 1);

    cur_req = "R8 R9 random mix";
    for (int i = 0; i < 6000; i++) begin
      int p = int'($urandom_range(0, 99));
      int v = int'($urandom_range(0, 255)) & 8'h8D;
      step(p < 70, p >= 95, v, (p >= 90 && p < 93) || p == 99);
    end

    done = 1'b1;
    finish_run();
  end
endmodule